// File: doc/BRIEF.md
# Palette Lookup with Flash and Video Inversion

This block turns a 4-bit logical pixel colour into a 3-bit digital RGB value on every pixel clock. It holds a small palette memory that the host writes one byte at a time. The upper nibble of the byte selects the entry, and the lower nibble is the stored word. Each stored word keeps its colour in inverted form, along with one flash bit. A global flash-enable control bit decides whether entries that carry the flash bit show their colour as stored or re-inverted. Flashing is produced by toggling that control bit over time.

After the palette read, the colour passes through a whole-screen reverse-video inversion and then a cursor inversion. Blanking forces the output dark whatever the other inputs are. The result goes through one register, so the RGB pins change only on clock edges. Palette reads are combinational from the entry registers. A write becomes visible to reads in the cycle after the write edge.

Top module: `palette_cam`

## Requirements
- R1: A write with `wr_en` high stores `wr_data[3:0]` in the entry selected by `wr_data[7:4]`. A pixel index that reads that entry in a later cycle sees the new word. A read of the same entry in the write cycle itself still sees the old word.
- R2: The stored word uses bit 0 = inverted red, bit 1 = inverted green, bit 2 = inverted blue and bit 3 = flash. When the flash bit is 0 or `flash_en` is 0, the output shows red = NOT bit 0, green = NOT bit 1 and blue = NOT bit 2.
- R3: When the entry's flash bit and `flash_en` are both 1, the output shows the stored bits unchanged: red = bit 0, green = bit 1, blue = bit 2.
- R4: While `disp_en` is 0, all three outputs are 0 whatever the palette, reverse-video and cursor inputs are.
- R5: While `rev_video` is 1, all three colour bits are inverted after the flash decision.
- R6: While `cursor_inv` is 1, all three colour bits are inverted after the reverse-video stage. With both `rev_video` and `cursor_inv` at 1, the two inversions cancel.
- R7: The outputs are registered. The value seen after clock edge k is formed from the inputs and palette contents present just before edge k.
- R8: Synchronous reset clears every entry to 0 and drives the outputs to 0. An entry cleared by reset and read with display enabled shows white.
- R9: After the 16-colour default write stream F8 E9 DA CB BC AD 9E 8F 70 61 52 43 34 25 16 07, logical colour n shows true colour n mod 8, read as a 3-bit number {blue,green,red}, when `flash_en` is 0. When `flash_en` is 1, colours n >= 8 show 7 - (n mod 8).
- R10: A write changes only the addressed entry. All other entries keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Palette write strobe |
| wr_data | input | 8 | Entry address in [7:4], stored word in [3:0] |
| pix_idx | input | 4 | Logical colour of the current pixel |
| flash_en | input | 1 | Global flash control bit |
| disp_en | input | 1 | Display enable; 0 blanks the output |
| rev_video | input | 1 | Whole-screen reverse video |
| cursor_inv | input | 1 | Cursor inversion for the current pixel |
| rgb_r | output | 1 | Red output |
| rgb_g | output | 1 | Green output |
| rgb_b | output | 1 | Blue output |

## Verification
The bench builds the block with its default index width of four bits. With that width, all sixteen entries can be reached, and the full 16-colour default stream can be loaded and read back in both flash phases. The bench also covers every combination of blanking, reverse video and cursor over entries with and without the flash bit. It reads an entry in the same cycle it is written, and it reads the neighbours of a written entry, so the read-before-write timing and the isolation between entries are both observed at the RGB pins.

// File: rtl/palcam_pkg.sv
package palcam_pkg;

    localparam int WORD_W = 4;

    typedef struct packed {
        logic flash;
        logic nb;
        logic ng;
        logic nr;
    } pal_word_t;

    typedef struct packed {
        logic b;
        logic g;
        logic r;
    } rgb_t;

    function automatic rgb_t word_colour(pal_word_t w);
        rgb_t c;
        c.b = w.nb;
        c.g = w.ng;
        c.r = w.nr;
        return c;
    endfunction

    function automatic rgb_t flip_if(rgb_t c, logic en);
        rgb_t o;
        o.b = c.b ^ en;
        o.g = c.g ^ en;
        o.r = c.r ^ en;
        return o;
    endfunction

endpackage

// File: rtl/palcam_store.sv
module palcam_store
    import palcam_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  pal_word_t        wr_word,
    input  logic [IDX_W-1:0] rd_addr,
    output pal_word_t        rd_word
);
    localparam int DEPTH = 1 << IDX_W;

    pal_word_t entry [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        logic hit;
        assign hit = wr_en && (wr_addr == IDX_W'(i));
        always_ff @(posedge clk) begin
            if (rst) begin
                entry[i] <= '0;
            end else if (hit) begin
                entry[i] <= wr_word;
            end
        end
    end

    assign rd_word = entry[rd_addr];

endmodule

// File: rtl/palcam_resolve.sv
module palcam_resolve
    import palcam_pkg::*;
(
    input  pal_word_t rd_word,
    input  logic      flash_en,
    input  logic      rev_video,
    input  logic      cursor_inv,
    input  logic      disp_en,
    output rgb_t      pre_cursor,
    output rgb_t      rgb_nxt
);
    logic keep_inverted;
    rgb_t after_flash;
    rgb_t after_cursor;

    always_comb begin
        keep_inverted = rd_word.flash & flash_en;
        after_flash   = flip_if(word_colour(rd_word), ~keep_inverted);
        pre_cursor    = flip_if(after_flash, rev_video);
        after_cursor  = flip_if(pre_cursor, cursor_inv);
        rgb_nxt       = disp_en ? after_cursor : '0;
    end

endmodule

// File: rtl/palcam_outreg.sv
module palcam_outreg
    import palcam_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  rgb_t d,
    output rgb_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/palette_cam.sv
module palette_cam
    import palcam_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W+3:0] wr_data,
    input  logic [IDX_W-1:0] pix_idx,
    input  logic             flash_en,
    input  logic             disp_en,
    input  logic             rev_video,
    input  logic             cursor_inv,
    output logic             rgb_r,
    output logic             rgb_g,
    output logic             rgb_b
);
    pal_word_t wr_word;
    pal_word_t rd_word;
    rgb_t      pre_cursor;
    rgb_t      rgb_nxt;
    rgb_t      rgb_q;

    assign wr_word = pal_word_t'(wr_data[WORD_W-1:0]);

    palcam_store #(.IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_data[IDX_W+3:WORD_W]),
        .wr_word (wr_word),
        .rd_addr (pix_idx),
        .rd_word (rd_word)
    );

    palcam_resolve u_resolve (
        .rd_word    (rd_word),
        .flash_en   (flash_en),
        .rev_video  (rev_video),
        .cursor_inv (cursor_inv),
        .disp_en    (disp_en),
        .pre_cursor (pre_cursor),
        .rgb_nxt    (rgb_nxt)
    );

    palcam_outreg u_out (
        .clk (clk),
        .rst (rst),
        .d   (rgb_nxt),
        .q   (rgb_q)
    );

    assign rgb_r = rgb_q.r;
    assign rgb_g = rgb_q.g;
    assign rgb_b = rgb_q.b;

endmodule

// File: rtl/palette_cam_chk.sv
module palette_cam_chk #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [IDX_W+3:0] wr_data,
    input logic [IDX_W-1:0] pix_idx,
    input logic             flash_en,
    input logic             disp_en,
    input logic             rev_video,
    input logic             cursor_inv,
    input logic             rgb_r,
    input logic             rgb_g,
    input logic             rgb_b,
    input logic [3:0]       rd_word
);
    logic [2:0] out;
    logic       hold;
    assign out  = {rgb_b, rgb_g, rgb_r};
    assign hold = rd_word[3] & flash_en;

    AST_RESET_DARK: assert property (@(posedge clk)
        rst |=> out == 3'b000); // R8

    AST_BLANK_DARK: assert property (@(posedge clk) disable iff (rst)
        !disp_en |=> out == 3'b000); // R4

    AST_TRUE_COLOUR: assert property (@(posedge clk) disable iff (rst)
        disp_en && !rev_video && !cursor_inv && !hold |=> out == ~$past(rd_word[2:0])); // R2

    AST_FLASH_HOLD: assert property (@(posedge clk) disable iff (rst)
        disp_en && !rev_video && !cursor_inv && hold |=> out == $past(rd_word[2:0])); // R3

    AST_REVERSE_ONLY: assert property (@(posedge clk) disable iff (rst)
        disp_en && rev_video && !cursor_inv && !hold |=> out == $past(rd_word[2:0])); // R5

    AST_CURSOR_CANCEL: assert property (@(posedge clk) disable iff (rst)
        disp_en && rev_video && cursor_inv && !hold |=> out == ~$past(rd_word[2:0])); // R6

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (pix_idx != $past(wr_data[IDX_W+3:4])) || (rd_word == $past(wr_data[3:0]))); // R1

endmodule

bind palette_cam palette_cam_chk #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .pix_idx    (pix_idx),
    .flash_en   (flash_en),
    .disp_en    (disp_en),
    .rev_video  (rev_video),
    .cursor_inv (cursor_inv),
    .rgb_r      (rgb_r),
    .rgb_g      (rgb_g),
    .rgb_b      (rgb_b),
    .rd_word    (rd_word)
);

// File: tb/sim_palette_cam.sv
module sim_palette_cam;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [3:0] pix_idx = '0;
    logic       flash_en = 1'b0;
    logic       disp_en = 1'b0;
    logic       rev_video = 1'b0;
    logic       cursor_inv = 1'b0;
    logic       rgb_r, rgb_g, rgb_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [3:0] model [16];
    logic [2:0] exp_q [$];
    string      tag_q [$];

    always #5 clk = ~clk;

    palette_cam u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .pix_idx(pix_idx), .flash_en(flash_en), .disp_en(disp_en),
        .rev_video(rev_video), .cursor_inv(cursor_inv),
        .rgb_r(rgb_r), .rgb_g(rgb_g), .rgb_b(rgb_b)
    );

    // Expected {b,g,r} from the requirements: R2/R3 flash, R5 reverse, R6 cursor, R4 blank
    function automatic logic [2:0] expect_rgb(logic [3:0] w, logic fe, logic de,
                                             logic rv, logic cu);
        logic [2:0] c;
        c = (w[3] && fe) ? w[2:0] : ~w[2:0];
        if (rv) c = ~c;
        if (cu) c = ~c;
        if (!de) c = 3'b000;
        return c;
    endfunction

    // Driver: applies one cycle of stimulus and queues its expected result (R7)
    task automatic drive(input logic we, input logic [7:0] wd, input logic [3:0] idx,
                         input logic fe, input logic de, input logic rv,
                         input logic cu, input string tag);
        @(negedge clk);
        wr_en = we; wr_data = wd; pix_idx = idx;
        flash_en = fe; disp_en = de; rev_video = rv; cursor_inv = cu;
        exp_q.push_back(expect_rgb(model[idx], fe, de, rv, cu));
        tag_q.push_back(tag);
        if (we) model[wd[7:4]] = wd[3:0];
    endtask

    // Monitor: compares each result shortly after the edge that produced it
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [2:0] e;
                logic [2:0] a;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {rgb_b, rgb_g, rgb_r};
                checks++;
                if (a !== e) begin
                    fails++;
                    $display("FAIL %s: rgb(bgr)=%b expected %b", t, a, e);
                end
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    logic [7:0] dflt [16];

    initial begin
        dflt = '{8'hF8, 8'hE9, 8'hDA, 8'hCB, 8'hBC, 8'hAD, 8'h9E, 8'h8F,
                 8'h70, 8'h61, 8'h52, 8'h43, 8'h34, 8'h25, 8'h16, 8'h07};
        for (int i = 0; i < 16; i++) model[i] = 4'h0;

        // R8: outputs dark while reset is held, even with display enabled
        repeat (3) @(negedge clk);
        disp_en = 1'b1;
        @(negedge clk);
        checks++;
        if ({rgb_b, rgb_g, rgb_r} !== 3'b000) begin
            fails++;
            $display("FAIL R8 reset output: rgb=%b expected 000", {rgb_b, rgb_g, rgb_r});
        end
        rst = 1'b0;

        // R8: cleared entry reads as white
        drive(0, 8'h00, 4'd3, 0, 1, 0, 0, "R8 cleared entry white");
        drive(0, 8'h00, 4'd15, 1, 1, 0, 0, "R8 cleared entry white flash on");

        // R1/R7: write entry 5 and read it the same cycle (old), then next cycle (new)
        drive(1, 8'h5A, 4'd5, 0, 1, 0, 0, "R1 same-cycle read sees old word");
        drive(0, 8'h00, 4'd5, 0, 1, 0, 0, "R1 next-cycle read sees new word");
        drive(0, 8'h00, 4'd5, 1, 1, 0, 0, "R3 flash word held inverted");
        // R10: neighbours untouched
        drive(0, 8'h00, 4'd4, 0, 1, 0, 0, "R10 entry 4 untouched");
        drive(0, 8'h00, 4'd6, 0, 1, 0, 0, "R10 entry 6 untouched");

        // R9: default stream
        for (int i = 0; i < 16; i++)
            drive(1, dflt[i], 4'd0, 0, 1, 0, 0, "R9 load stream");
        for (int n = 0; n < 16; n++) begin
            drive(0, 8'h00, 4'(n), 0, 1, 0, 0, "R9 R2 default colour flash off");
            checks++;
            if (exp_q[exp_q.size()-1] !== 3'(n % 8)) begin
                fails++;
                $display("FAIL R9 model: expected %0d got %0d", n % 8, exp_q[exp_q.size()-1]);
            end
        end
        for (int n = 0; n < 16; n++) begin
            drive(0, 8'h00, 4'(n), 1, 1, 0, 0, "R9 R3 default colour flash on");
            checks++;
            if (exp_q[exp_q.size()-1] !== ((n >= 8) ? 3'(7 - n % 8) : 3'(n % 8))) begin
                fails++;
                $display("FAIL R9 model flash: n=%0d got %0d", n, exp_q[exp_q.size()-1]);
            end
        end

        // R4/R5/R6: all modifier combinations on a flashing and a steady entry
        for (int k = 0; k < 16; k++) begin
            drive(0, 8'h00, 4'd2, k[0], k[1], k[2], k[3], "R4 R5 R6 steady entry");
            drive(0, 8'h00, 4'd10, k[0], k[1], k[2], k[3], "R4 R5 R6 flash entry");
        end
        drive(0, 8'h00, 4'd7, 0, 0, 1, 1, "R4 blank over cursor and reverse");
        drive(0, 8'h00, 4'd1, 0, 1, 1, 1, "R6 cursor cancels reverse");
        drive(0, 8'h00, 4'd1, 0, 1, 0, 1, "R6 cursor alone");
        drive(0, 8'h00, 4'd1, 0, 1, 1, 0, "R5 reverse alone");

        // R1/R10: overwrite entry 9 while blanked, then read it and entry 8
        drive(1, 8'h93, 4'd9, 0, 0, 0, 0, "R4 blank during write");
        drive(0, 8'h00, 4'd9, 0, 1, 0, 0, "R1 entry 9 rewritten");
        drive(0, 8'h00, 4'd8, 0, 1, 0, 0, "R10 entry 8 untouched");
        drive(0, 8'h00, 4'd0, 0, 1, 0, 0, "R7 idle");

        repeat (3) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule